// File: doc/BRIEF.md
# Multi-Frame Sequence Divider with Frame-ID Resync

This block counts output video frames in a repeating sequence of five or ten frames. The length depends on the frame rate in use. It marks the first frame of each sequence with a one-cycle pulse. An external frame-identification level can realign the count, so that a downstream timing generator stays in step with an upstream reference whose sequence phase is carried on that level.

A second counter tracks the audio frame sequence and uses the same modulus. By default the frame-ID level realigns the audio counter together with the video counter. A host control bit can uncouple the two, and the audio sequence then runs on undisturbed. Every frame whose boundary sees the frame-ID level high also produces an audio clock phase-reset strobe. That strobe is timed from the horizontal sync leading edge on line 1. When the frame-ID level stays low, both counters run freely.

A frame boundary is a clock cycle in which the horizontal sync leading-edge pulse and the line-1 indicator are both high. Every result is registered once and appears on the cycle after the boundary.

Top module: `frame_seq_divider`

## Requirements
- R1: After synchronous reset, `marker_o`, `aud_start_o` and `aud_phase_rst_o` are 0 and `aud_seq_o` is 0.
- R2: Counters and outputs change only at a frame boundary (`hs_lead_i` and `line1_i` both high in the same cycle). A horizontal sync pulse off line 1, or line 1 without a sync pulse, produces no pulse.
- R3: With `rate_sel_i` = 0 the sequence length is 5 frames. With `rate_sel_i` = 1 it is 10 frames. Each boundary advances a counter by one, wrapping from length-1 to 0.
- R4: `marker_o` is a one-cycle pulse, high in the cycle after a boundary at which the video frame index becomes 0 (frame 1 of the sequence).
- R5: If `fid_i` is high at a boundary, the video index is loaded with 0, so `marker_o` pulses after that boundary.
- R6: If `fid_i` is high at a boundary and `aud_couple_i` is 1, the audio index is loaded with 0 as well. With `aud_couple_i` = 0 the audio index advances as usual.
- R7: `aud_phase_rst_o` pulses for one cycle after every boundary at which `fid_i` is high, whatever the value of `aud_couple_i`.
- R8: `aud_seq_o` shows the audio frame index and updates in the cycle after a boundary. `aud_start_o` pulses in the cycle after a boundary at which that index becomes 0.
- R9: A boundary at which `rate_sel_i` differs from its value at the previous boundary loads both indices with 0, even when `fid_i` is low. The reset value of the remembered rate is 0.
- R10: `fid_i` is sampled only at boundaries. A high level on any other cycle does not change either index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_lead_i | input | 1 | One-cycle pulse at the leading edge of output horizontal sync |
| line1_i | input | 1 | High while the output is on line 1 |
| rate_sel_i | input | 1 | 0: 5-frame sequence (29.97/30 fps), 1: 10-frame sequence (59.94/60 fps) |
| fid_i | input | 1 | External frame-identification level |
| aud_couple_i | input | 1 | 1: frame-ID also realigns the audio sequence; 0: it does not |
| marker_o | output | 1 | Sequence-start marker pulse |
| aud_seq_o | output | 4 | Audio frame sequence index |
| aud_start_o | output | 1 | Audio sequence start pulse |
| aud_phase_rst_o | output | 1 | Audio clock phase-reset strobe |

## Verification
All four results pass through exactly one register, so each is due one clock after the rising edge that captures a boundary. The driver applies a boundary for one cycle. For each boundary it queues the expected marker, audio index, start flag and phase strobe from a reference count. The monitor records whether a boundary was present at each rising edge and compares the queued item at the following falling edge. On every edge without a boundary it checks that no pulse appears. Stray sync pulses and frame-ID levels between boundaries therefore land in cycles where the expected answer is "nothing".

// File: rtl/fsd_pkg.sv
package fsd_pkg;
   typedef enum logic {
      RATE_LO = 1'b0,
      RATE_HI = 1'b1
   } rate_e;

   localparam int NUM_SEQ = 2;
   localparam int SEQ_VID = 0;
   localparam int SEQ_AUD = 1;
endpackage

// File: rtl/fsd_ctl.sv
module fsd_ctl
   import fsd_pkg::*;
#(
   parameter int FRAMES_LO = 5,
   parameter int FRAMES_HI = 10,
   parameter int CW        = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                hs_lead_i,
   input  logic                line1_i,
   input  logic                rate_sel_i,
   input  logic                fid_i,
   input  logic                aud_couple_i,
   output logic                step_o,
   output logic [NUM_SEQ-1:0]  clr_o,
   output logic [CW-1:0]       last_o,
   output logic                phase_o
);
   localparam logic [CW-1:0] LAST_LO = CW'(FRAMES_LO - 1);
   localparam logic [CW-1:0] LAST_HI = CW'(FRAMES_HI - 1);

   rate_e rate_q;
   logic  boundary;
   logic  rate_chg;

   assign boundary = hs_lead_i & line1_i;
   assign rate_chg = boundary & (rate_e'(rate_sel_i) != rate_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         rate_q  <= RATE_LO;
         phase_o <= 1'b0;
      end else begin
         phase_o <= boundary & fid_i;
         if (boundary) rate_q <= rate_e'(rate_sel_i);
      end
   end

   assign step_o         = boundary;
   assign clr_o[SEQ_VID] = boundary & (rate_chg | fid_i);
   assign clr_o[SEQ_AUD] = boundary & (rate_chg | (fid_i & aud_couple_i));
   assign last_o         = (rate_q == RATE_HI) ? LAST_HI : LAST_LO;

   assert_rate_held_R9 : assert property (@(posedge clk) disable iff (rst)
      !boundary |=> $stable(rate_q));
   assert_phase_needs_line1_R7 : assert property (@(posedge clk) disable iff (rst)
      !line1_i |=> !phase_o);
endmodule

// File: rtl/fsd_seq_ctr.sv
module fsd_seq_ctr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_i,
   input  logic          clr_i,
   input  logic [CW-1:0] last_i,
   output logic [CW-1:0] cnt_o,
   output logic          first_o
);
   logic [CW-1:0] nxt;

   always_comb begin
      if (clr_i || cnt_o >= last_i) nxt = '0;
      else                          nxt = cnt_o + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_o   <= '0;
         first_o <= 1'b0;
      end else begin
         first_o <= step_i && (nxt == '0);
         if (step_i) cnt_o <= nxt;
      end
   end

   assert_in_range_R3 : assert property (@(posedge clk) disable iff (rst)
      cnt_o <= last_i);
   assert_hold_off_boundary_R2 : assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(cnt_o) && !first_o);
   assert_first_at_zero_R4 : assert property (@(posedge clk) disable iff (rst)
      first_o |-> cnt_o == '0);
endmodule

// File: rtl/frame_seq_divider.sv
module frame_seq_divider
   import fsd_pkg::*;
#(
   parameter int FRAMES_LO = 5,
   parameter int FRAMES_HI = 10,
   parameter int CW        = $clog2(FRAMES_HI)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hs_lead_i,
   input  logic          line1_i,
   input  logic          rate_sel_i,
   input  logic          fid_i,
   input  logic          aud_couple_i,
   output logic          marker_o,
   output logic [CW-1:0] aud_seq_o,
   output logic          aud_start_o,
   output logic          aud_phase_rst_o
);
   if (FRAMES_LO < 2) begin : g_chk_lo
      $error("FRAMES_LO must be at least 2");
   end
   if (FRAMES_HI <= FRAMES_LO) begin : g_chk_hi
      $error("FRAMES_HI must exceed FRAMES_LO");
   end
   if ((1 << CW) < FRAMES_HI) begin : g_chk_cw
      $error("CW too narrow for FRAMES_HI");
   end

   logic               step;
   logic [NUM_SEQ-1:0] clr;
   logic [CW-1:0]      last;
   logic [CW-1:0]      cnt   [NUM_SEQ];
   logic [NUM_SEQ-1:0] first;

   fsd_ctl #(
      .FRAMES_LO(FRAMES_LO),
      .FRAMES_HI(FRAMES_HI),
      .CW       (CW)
   ) u_ctl (
      .clk         (clk),
      .rst         (rst),
      .hs_lead_i   (hs_lead_i),
      .line1_i     (line1_i),
      .rate_sel_i  (rate_sel_i),
      .fid_i       (fid_i),
      .aud_couple_i(aud_couple_i),
      .step_o      (step),
      .clr_o       (clr),
      .last_o      (last),
      .phase_o     (aud_phase_rst_o)
   );

   for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
      fsd_seq_ctr #(.CW(CW)) u_ctr (
         .clk    (clk),
         .rst    (rst),
         .step_i (step),
         .clr_i  (clr[g]),
         .last_i (last),
         .cnt_o  (cnt[g]),
         .first_o(first[g])
      );
   end

   assign marker_o    = first[SEQ_VID];
   assign aud_start_o = first[SEQ_AUD];
   assign aud_seq_o   = cnt[SEQ_AUD];

   assert_fid_marker_R5 : assert property (@(posedge clk) disable iff (rst)
      (hs_lead_i && line1_i && fid_i) |=> marker_o);
   assert_aud_realign_R6 : assert property (@(posedge clk) disable iff (rst)
      (hs_lead_i && line1_i && fid_i && aud_couple_i) |=> (aud_start_o && aud_seq_o == '0));
   assert_phase_strobe_R7 : assert property (@(posedge clk) disable iff (rst)
      (hs_lead_i && line1_i && fid_i) |=> aud_phase_rst_o);
   assert_no_stray_fid_R10 : assert property (@(posedge clk) disable iff (rst)
      !(hs_lead_i && line1_i) |=> !aud_phase_rst_o && !marker_o);
endmodule

// File: tb/frame_seq_divider_tb.sv
module frame_seq_divider_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 4;

   typedef struct {
      logic          marker;
      logic [CW-1:0] seq;
      logic          start;
      logic          phase;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hs_lead = 1'b0, line1 = 1'b0, rate_sel = 1'b0, fid = 1'b0, couple = 1'b1;
   logic          marker, aud_start, aud_phase;
   logic [CW-1:0] aud_seq;

   int   checks = 0;
   int   errors = 0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;
   exp_t q[$];

   int   m_vid = 0, m_aud = 0;
   logic m_rate = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_seq_divider u_dut (
      .clk            (clk),
      .rst            (rst),
      .hs_lead_i      (hs_lead),
      .line1_i        (line1),
      .rate_sel_i     (rate_sel),
      .fid_i          (fid),
      .aud_couple_i   (couple),
      .marker_o       (marker),
      .aud_seq_o      (aud_seq),
      .aud_start_o    (aud_start),
      .aud_phase_rst_o(aud_phase)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: one boundary, model update, expected item queued, then idle cycles with stray activity.
   task automatic frame(input logic f, input logic r, input logic c, input logic stray, input string tag);
      exp_t e;
      int   n;
      @(negedge clk);
      fid = f; rate_sel = r; couple = c; hs_lead = 1'b1; line1 = 1'b1;
      if (r != m_rate) begin
         m_vid = 0; m_aud = 0; m_rate = r;
      end else begin
         n = m_rate ? 10 : 5;
         m_vid = f ? 0 : ((m_vid >= n-1) ? 0 : m_vid + 1);
         m_aud = (f && c) ? 0 : ((m_aud >= n-1) ? 0 : m_aud + 1);
      end
      e.marker = (m_vid == 0);
      e.seq    = CW'(m_aud);
      e.start  = (m_aud == 0);
      e.phase  = f;
      e.tag    = tag;
      q.push_back(e);
      @(negedge clk);
      hs_lead = 1'b0; line1 = 1'b0; fid = stray;
      hs_lead = 1'b1;                       // sync pulse off line 1 (R2, R10)
      @(negedge clk);
      hs_lead = 1'b0; line1 = 1'b1;         // line 1 without sync pulse
      @(negedge clk);
      line1 = 1'b0; fid = 1'b0;
   endtask

   // Monitor: results are due one edge after the boundary edge.
   initial begin
      forever begin
         bit b;
         @(posedge clk);
         b = hs_lead && line1;
         @(negedge clk);
         if (mon_en) begin
            if (b) begin
               if (q.size() == 0) begin
                  chk("R2 unexpected boundary", 1, 0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  chk({e.tag, " R4 marker"}, marker, e.marker);
                  chk({e.tag, " R8 aud_seq"}, aud_seq, e.seq);
                  chk({e.tag, " R8 aud_start"}, aud_start, e.start);
                  chk({e.tag, " R7 phase"}, aud_phase, e.phase);
               end
            end else begin
               chk("R2/R10 quiet marker", marker, 0);
               chk("R2/R10 quiet start", aud_start, 0);
               chk("R2/R10 quiet phase", aud_phase, 0);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 marker", marker, 0);
      chk("R1 aud_start", aud_start, 0);
      chk("R1 phase", aud_phase, 0);
      chk("R1 aud_seq", aud_seq, 0);
      mon_en = 1'b1;
      // R3/R4/R8: free running, 5-frame sequence
      for (int i = 0; i < 12; i++) frame(1'b0, 1'b0, 1'b1, 1'b0, "R3 lo");
      // R5/R6/R7: frame-ID resync, coupled
      frame(1'b1, 1'b0, 1'b1, 1'b0, "R5 R6 coupled");
      for (int i = 0; i < 3; i++) frame(1'b0, 1'b0, 1'b1, 1'b0, "R3 after");
      // R6: uncoupled, audio keeps running
      frame(1'b1, 1'b0, 1'b0, 1'b0, "R6 uncoupled");
      for (int i = 0; i < 6; i++) frame(1'b0, 1'b0, 1'b0, 1'b0, "R6 run");
      // R9: rate change clears both
      frame(1'b0, 1'b1, 1'b1, 1'b0, "R9 to hi");
      for (int i = 0; i < 22; i++) frame(1'b0, 1'b1, 1'b1, 1'b0, "R3 hi");
      // R10: stray frame-ID between boundaries
      for (int i = 0; i < 4; i++) frame(1'b0, 1'b1, 1'b1, 1'b1, "R10 stray");
      frame(1'b1, 1'b1, 1'b1, 1'b1, "R5 hi");
      for (int i = 0; i < 3; i++) frame(1'b0, 1'b1, 1'b1, 1'b0, "R3 hi2");
      frame(1'b0, 1'b0, 1'b1, 1'b0, "R9 to lo");
      for (int i = 0; i < 6; i++) frame(1'b0, 1'b0, 1'b1, 1'b0, "R3 lo2");
      repeat (3) @(negedge clk);
      chk("R2 queue drained", q.size(), 0);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule